// File: doc/BRIEF.md
# Serial Display-Command Receiver

This block sits behind the three-wire host link of a dot-matrix fluorescent display controller. The host pulls the active-low select line low, then clocks bytes in least-significant bit first on the rising edge of the shift clock. The block gathers the bits into bytes and treats the first byte after select falls as a command. Later bytes in the same selection are that command's data. The block turns this stream into write strobes, addresses and data for three small memories. Each memory exists in two banks: a 16-entry character-code store (8 bits wide), a 16-entry glyph store (35 bits wide, a 5-column by 7-row dot field) and a 16-entry marker store (1 bit wide). The block also holds three settings: a 10-bit brightness duty, a 4-bit digit count and a 2-bit force-lamps mode.

The whole block runs on the shift clock. The memories, scan timing and drivers downstream resynchronise what they need. The internal byte engine resets asynchronously whenever select is high or the main reset is low, so a new selection always starts on a byte boundary in the command state. The settings and the memory write port are cleared only by the main reset.

The decoder is a six-state machine. IDLE_CMD waits for a command byte. CODE_DATA, GLYPH_DATA and MARK_DATA stream memory data and advance the address. DUTY_HI waits for the upper duty byte. DROP swallows every byte until select rises. From IDLE_CMD, a memory command moves the machine to its data state. The duty command moves it to DUTY_HI. The digit-count command, the force-lamps command and every unknown code move it to DROP. DUTY_HI always moves to DROP. The three data states stay where they are. Any state returns to IDLE_CMD when select rises or reset is asserted.

Top module: `vfd_cmd_rx`

## Requirements
- R1: Bits are taken from `da` on each rising `cp` edge while `cs_n` is low, the first one as bit 0. They group into bytes counted from the moment `cs_n` falls. Raising `cs_n` discards a partial byte, so the next complete byte is decoded as a command.
- R2: A command byte whose bits [6:4] are 001 starts a character-code write. Bit 7 picks the bank (0 = A, 1 = B) and bits [3:0] give the start address. Each following byte raises `code_we[bank]` for one `cp` period, starting at the edge that takes in its last bit, with `code_addr` and `code_data` valid for that period.
- R3: In all three memory write modes, each stored entry advances the address by one, and address 15 is followed by address 0.
- R4: A command byte with bits [6:4] = 010 starts a glyph write (bank in bit 7, address in [3:0]). Five data bytes form one entry: bit r (r = 0..6) of byte k (k = 0..4) goes to `glyph_data[k + 5*r]`, and bit 7 is ignored. The strobe appears only after the fifth byte.
- R5: A command byte with bits [6:4] = 011 starts a marker write (bank in bit 7, address in [3:0]). Only bit 0 of each data byte reaches `mark_data`.
- R6: A command byte with bits [7:4] = 0101 carries duty bits [1:0] in its bits [1:0]. The next byte supplies duty bits [9:2]. `duty` changes only when that second byte completes, and bytes after it are ignored.
- R7: A command byte with bits [7:4] = 0110 loads `digits` from bits [3:0]. A command byte with bits [7:4] = 0111 loads `lamps` from bits [1:0] (bit 0 forces low, bit 1 forces high). Bytes that follow either command are ignored.
- R8: Any other command byte, including 1111xxxx, changes nothing. No byte that follows it in the same selection causes a write or a setting change.
- R9: After reset, all strobes are low, `duty` is 0, `digits` is 0 (sixteen digits) and `lamps` is 01 (all outputs forced low).
- R10: At most one write strobe is high in any cycle, and no strobe stays high for two consecutive cycles.
- R11: Raising `cs_n` after fewer than five glyph data bytes drops the partial entry without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cp | input | 1 | Shift clock; the block's only clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts the current transfer |
| da | input | 1 | Serial data, least-significant bit first |
| code_we | output | 2 | Character-code store write strobes, one per bank |
| code_addr | output | 4 | Character-code store address |
| code_data | output | 8 | Character code to store |
| glyph_we | output | 2 | Glyph store write strobes, one per bank |
| glyph_addr | output | 4 | Glyph store address |
| glyph_data | output | 35 | Assembled 35-dot glyph entry |
| mark_we | output | 2 | Marker store write strobes, one per bank |
| mark_addr | output | 4 | Marker store address |
| mark_data | output | 1 | Marker bit to store |
| duty | output | 10 | Brightness duty setting |
| digits | output | 4 | Digit-count setting (0 means sixteen) |
| lamps | output | 2 | Force-lamps mode |

## Verification
A bit counter that is off by one would misframe every byte after it. The ports would show wrong codes, or commands treated as data, on the first strobe after the fault. A pointer that skips or fails to wrap shows up as a wrong address on the very next write in a long burst. A glyph column counter that is not cleared when select rises produces a write after the wrong number of bytes in the following selection, visible within five bytes. A decoder that leaves DROP, or decodes a bad code as a real command, shows up as a stray strobe or a changed setting before select rises again.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;

    localparam int BYTE_W = 8;

    // reset value of the force-lamps mode: bit0 = force low
    localparam logic [1:0] LAMPS_RST = 2'b01;

    typedef enum logic [2:0] {
        IDLE_CMD,
        CODE_DATA,
        GLYPH_DATA,
        MARK_DATA,
        DUTY_HI,
        DROP
    } rx_state_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CODE,
        OP_GLYPH,
        OP_MARK,
        OP_DUTY,
        OP_DIGITS,
        OP_LAMPS
    } rx_op_t;

    function automatic rx_op_t decode_op(input logic [BYTE_W-1:0] b);
        rx_op_t op;
        op = OP_NONE;
        case (b[6:4])
            3'b001:  op = OP_CODE;
            3'b010:  op = OP_GLYPH;
            3'b011:  op = OP_MARK;
            3'b101:  op = b[7] ? OP_NONE : OP_DUTY;
            3'b110:  op = b[7] ? OP_NONE : OP_DIGITS;
            3'b111:  op = b[7] ? OP_NONE : OP_LAMPS;
            default: op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/vfd_bit_shifter.sv
module vfd_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              cp,
    input  logic              clr_n,
    input  logic              da,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;

    // LSB first: new bits enter at the top and move down
    always_ff @(posedge cp or negedge clr_n) begin
        if (!clr_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            shreg   <= {da, shreg[BYTE_W-2:1]};
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
    end

    always_comb begin
        byte_done = (bit_cnt == LAST_BIT);
        byte_val  = {da, shreg};
    end

    // R1
    bit_restart_chk: assert property (@(posedge cp) disable iff (!clr_n)
        byte_done |=> (bit_cnt == '0));

endmodule

// File: rtl/vfd_glyph_packer.sv
module vfd_glyph_packer #(
    parameter int COLS = 5,
    parameter int ROWS = 7
) (
    input  logic                    cp,
    input  logic                    clr_n,
    input  logic                    load,
    input  logic [$clog2(COLS)-1:0] col,
    input  logic [ROWS-1:0]         row_bits,
    output logic [COLS*ROWS-1:0]    glyph_full
);
    localparam int PAT_W = COLS * ROWS;
    localparam int COL_W = $clog2(COLS);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic [PAT_W-1:0] acc;
    logic [PAT_W-1:0] merged;

    // dot i belongs to column i%COLS, row i/COLS
    for (genvar i = 0; i < PAT_W; i++) begin : g_dot
        localparam int C = i % COLS;
        localparam int R = i / COLS;
        assign merged[i] = (col == COL_W'(C)) ? row_bits[R] : acc[i];
    end

    always_ff @(posedge cp or negedge clr_n) begin
        if (!clr_n) begin
            acc <= '0;
        end else if (load) begin
            acc <= (col == LAST_COL) ? '0 : merged;
        end
    end

    assign glyph_full = merged;

endmodule

// File: rtl/vfd_cmd_fsm.sv
module vfd_cmd_fsm
    import vfd_cmd_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int COLS    = 5,
    parameter int DUTY_W  = 10,
    parameter int DIG_W   = 4,
    parameter int LAMPS_W = 2
) (
    input  logic                    cp,
    input  logic                    clr_n,
    input  logic                    byte_done,
    input  logic [BYTE_W-1:0]       byte_val,
    output logic                    code_req,
    output logic                    glyph_req,
    output logic                    glyph_load,
    output logic                    mark_req,
    output logic [$clog2(COLS)-1:0] col,
    output logic                    wr_bank,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic                    duty_req,
    output logic [DUTY_W-1:0]       duty_val,
    output logic                    digit_req,
    output logic [DIG_W-1:0]        digit_val,
    output logic                    lamps_req,
    output logic [LAMPS_W-1:0]      lamps_val
);
    localparam int COL_W   = $clog2(COLS);
    localparam int DLO_W   = DUTY_W - BYTE_W;
    localparam logic [COL_W-1:0]  LAST_COL = COL_W'(COLS - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    rx_state_t          state, nxt_state;
    logic               bank, nxt_bank;
    logic [ADDR_W-1:0]  ptr, nxt_ptr;
    logic [COL_W-1:0]   col_q, nxt_col;
    logic [DLO_W-1:0]   dlo, nxt_dlo;
    rx_op_t             op;

    always_comb op = decode_op(byte_val);

    // state register
    always_ff @(posedge cp or negedge clr_n) begin
        if (!clr_n) begin
            state <= IDLE_CMD;
            bank  <= 1'b0;
            ptr   <= '0;
            col_q <= '0;
            dlo   <= '0;
        end else begin
            state <= nxt_state;
            bank  <= nxt_bank;
            ptr   <= nxt_ptr;
            col_q <= nxt_col;
            dlo   <= nxt_dlo;
        end
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_bank  = bank;
        nxt_ptr   = ptr;
        nxt_col   = col_q;
        nxt_dlo   = dlo;
        if (byte_done) begin
            unique case (state)
                IDLE_CMD: begin
                    nxt_bank = byte_val[BYTE_W-1];
                    nxt_ptr  = byte_val[ADDR_W-1:0];
                    nxt_col  = '0;
                    nxt_dlo  = byte_val[DLO_W-1:0];
                    case (op)
                        OP_CODE:  nxt_state = CODE_DATA;
                        OP_GLYPH: nxt_state = GLYPH_DATA;
                        OP_MARK:  nxt_state = MARK_DATA;
                        OP_DUTY:  nxt_state = DUTY_HI;
                        default:  nxt_state = DROP;
                    endcase
                end
                CODE_DATA, MARK_DATA: begin
                    nxt_ptr = ptr + 1'b1;
                end
                GLYPH_DATA: begin
                    if (col_q == LAST_COL) begin
                        nxt_col = '0;
                        nxt_ptr = ptr + 1'b1;
                    end else begin
                        nxt_col = col_q + 1'b1;
                    end
                end
                DUTY_HI: nxt_state = DROP;
                DROP:    nxt_state = DROP;
            endcase
        end
    end

    // output logic
    always_comb begin
        code_req   = 1'b0;
        glyph_req  = 1'b0;
        glyph_load = 1'b0;
        mark_req   = 1'b0;
        duty_req   = 1'b0;
        digit_req  = 1'b0;
        lamps_req  = 1'b0;
        if (byte_done) begin
            unique case (state)
                IDLE_CMD: begin
                    digit_req = (op == OP_DIGITS);
                    lamps_req = (op == OP_LAMPS);
                end
                CODE_DATA:  code_req = 1'b1;
                GLYPH_DATA: begin
                    glyph_load = 1'b1;
                    glyph_req  = (col_q == LAST_COL);
                end
                MARK_DATA:  mark_req = 1'b1;
                DUTY_HI:    duty_req = 1'b1;
                DROP:       ;
            endcase
        end
        col       = col_q;
        wr_bank   = bank;
        wr_addr   = ptr;
        duty_val  = {byte_val, dlo};
        digit_val = byte_val[DIG_W-1:0];
        lamps_val = byte_val[LAMPS_W-1:0];
    end

    // R3
    ptr_wrap_chk: assert property (@(posedge cp) disable iff (!clr_n)
        (byte_done && (state == CODE_DATA || state == MARK_DATA) && ptr == TOP_ADDR)
        |=> (ptr == '0));

    // R4
    col_range_chk: assert property (@(posedge cp) disable iff (!clr_n)
        col_q <= LAST_COL);

    // R8
    drop_sticky_chk: assert property (@(posedge cp) disable iff (!clr_n)
        (state == DROP) |=> (state == DROP));

endmodule

// File: rtl/vfd_wr_stage.sv
module vfd_wr_stage #(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 8,
    parameter int PAT_W  = 35,
    parameter int NBANK  = 2
) (
    input  logic              cp,
    input  logic              rst_n,
    input  logic              code_req,
    input  logic              glyph_req,
    input  logic              mark_req,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] byte_val,
    input  logic [PAT_W-1:0]  glyph_full,
    output logic [NBANK-1:0]  code_we,
    output logic [ADDR_W-1:0] code_addr,
    output logic [CODE_W-1:0] code_data,
    output logic [NBANK-1:0]  glyph_we,
    output logic [ADDR_W-1:0] glyph_addr,
    output logic [PAT_W-1:0]  glyph_data,
    output logic [NBANK-1:0]  mark_we,
    output logic [ADDR_W-1:0] mark_addr,
    output logic              mark_data
);
    logic [NBANK-1:0] bank_sel;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_sel[b] = (wr_bank == b[0]);
    end

    always_ff @(posedge cp or negedge rst_n) begin
        if (!rst_n) begin
            code_we    <= '0;
            code_addr  <= '0;
            code_data  <= '0;
            glyph_we   <= '0;
            glyph_addr <= '0;
            glyph_data <= '0;
            mark_we    <= '0;
            mark_addr  <= '0;
            mark_data  <= 1'b0;
        end else begin
            code_we  <= code_req  ? bank_sel : '0;
            glyph_we <= glyph_req ? bank_sel : '0;
            mark_we  <= mark_req  ? bank_sel : '0;
            if (code_req) begin
                code_addr <= wr_addr;
                code_data <= byte_val;
            end
            if (glyph_req) begin
                glyph_addr <= wr_addr;
                glyph_data <= glyph_full;
            end
            if (mark_req) begin
                mark_addr <= wr_addr;
                mark_data <= byte_val[0];
            end
        end
    end

    // R10
    one_strobe_chk: assert property (@(posedge cp) disable iff (!rst_n)
        $countones({code_we, glyph_we, mark_we}) <= 1);

    // R10
    strobe_pulse_chk: assert property (@(posedge cp) disable iff (!rst_n)
        (|{code_we, glyph_we, mark_we}) |=> !(|{code_we, glyph_we, mark_we}));

endmodule

// File: rtl/vfd_ctrl_regs.sv
module vfd_ctrl_regs
    import vfd_cmd_pkg::*;
#(
    parameter int DUTY_W  = 10,
    parameter int DIG_W   = 4,
    parameter int LAMPS_W = 2
) (
    input  logic               cp,
    input  logic               rst_n,
    input  logic               duty_req,
    input  logic [DUTY_W-1:0]  duty_val,
    input  logic               digit_req,
    input  logic [DIG_W-1:0]   digit_val,
    input  logic               lamps_req,
    input  logic [LAMPS_W-1:0] lamps_val,
    output logic [DUTY_W-1:0]  duty,
    output logic [DIG_W-1:0]   digits,
    output logic [LAMPS_W-1:0] lamps
);
    always_ff @(posedge cp or negedge rst_n) begin
        if (!rst_n) begin
            duty   <= '0;
            digits <= '0;
            lamps  <= LAMPS_W'(LAMPS_RST);
        end else begin
            if (duty_req)  duty   <= duty_val;
            if (digit_req) digits <= digit_val;
            if (lamps_req) lamps  <= lamps_val;
        end
    end

    // R6
    duty_hold_chk: assert property (@(posedge cp) disable iff (!rst_n)
        !duty_req |=> $stable(duty));

    // R7
    digits_hold_chk: assert property (@(posedge cp) disable iff (!rst_n)
        !digit_req |=> $stable(digits));

endmodule

// File: rtl/vfd_cmd_rx.sv
module vfd_cmd_rx
    import vfd_cmd_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int COLS    = 5,
    parameter int ROWS    = 7,
    parameter int DUTY_W  = 10,
    parameter int DIG_W   = 4,
    parameter int LAMPS_W = 2,
    parameter int NBANK   = 2
) (
    input  logic                    cp,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    da,
    output logic [NBANK-1:0]        code_we,
    output logic [ADDR_W-1:0]       code_addr,
    output logic [BYTE_W-1:0]       code_data,
    output logic [NBANK-1:0]        glyph_we,
    output logic [ADDR_W-1:0]       glyph_addr,
    output logic [COLS*ROWS-1:0]    glyph_data,
    output logic [NBANK-1:0]        mark_we,
    output logic [ADDR_W-1:0]       mark_addr,
    output logic                    mark_data,
    output logic [DUTY_W-1:0]       duty,
    output logic [DIG_W-1:0]        digits,
    output logic [LAMPS_W-1:0]      lamps
);
    localparam int PAT_W = COLS * ROWS;
    localparam int COL_W = $clog2(COLS);

    logic               frame_clr_n;
    logic               byte_done;
    logic [BYTE_W-1:0]  byte_val;
    logic               code_req, glyph_req, glyph_load, mark_req;
    logic [COL_W-1:0]   col;
    logic               wr_bank;
    logic [ADDR_W-1:0]  wr_addr;
    logic               duty_req, digit_req, lamps_req;
    logic [DUTY_W-1:0]  duty_val;
    logic [DIG_W-1:0]   digit_val;
    logic [LAMPS_W-1:0] lamps_val;
    logic [PAT_W-1:0]   glyph_full;

    // byte engine is held clear while deselected or in reset
    assign frame_clr_n = rst_n & ~cs_n;

    vfd_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .cp        (cp),
        .clr_n     (frame_clr_n),
        .da        (da),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    vfd_cmd_fsm #(
        .ADDR_W (ADDR_W), .COLS (COLS), .DUTY_W (DUTY_W),
        .DIG_W  (DIG_W),  .LAMPS_W (LAMPS_W)
    ) u_fsm (
        .cp         (cp),
        .clr_n      (frame_clr_n),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .code_req   (code_req),
        .glyph_req  (glyph_req),
        .glyph_load (glyph_load),
        .mark_req   (mark_req),
        .col        (col),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .duty_req   (duty_req),
        .duty_val   (duty_val),
        .digit_req  (digit_req),
        .digit_val  (digit_val),
        .lamps_req  (lamps_req),
        .lamps_val  (lamps_val)
    );

    vfd_glyph_packer #(.COLS(COLS), .ROWS(ROWS)) u_pack (
        .cp         (cp),
        .clr_n      (frame_clr_n),
        .load       (glyph_load),
        .col        (col),
        .row_bits   (byte_val[ROWS-1:0]),
        .glyph_full (glyph_full)
    );

    vfd_wr_stage #(
        .ADDR_W (ADDR_W), .CODE_W (BYTE_W), .PAT_W (PAT_W), .NBANK (NBANK)
    ) u_wr (
        .cp         (cp),
        .rst_n      (rst_n),
        .code_req   (code_req),
        .glyph_req  (glyph_req),
        .mark_req   (mark_req),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .byte_val   (byte_val),
        .glyph_full (glyph_full),
        .code_we    (code_we),
        .code_addr  (code_addr),
        .code_data  (code_data),
        .glyph_we   (glyph_we),
        .glyph_addr (glyph_addr),
        .glyph_data (glyph_data),
        .mark_we    (mark_we),
        .mark_addr  (mark_addr),
        .mark_data  (mark_data)
    );

    vfd_ctrl_regs #(.DUTY_W(DUTY_W), .DIG_W(DIG_W), .LAMPS_W(LAMPS_W)) u_ctrl (
        .cp        (cp),
        .rst_n     (rst_n),
        .duty_req  (duty_req),
        .duty_val  (duty_val),
        .digit_req (digit_req),
        .digit_val (digit_val),
        .lamps_req (lamps_req),
        .lamps_val (lamps_val),
        .duty      (duty),
        .digits    (digits),
        .lamps     (lamps)
    );

endmodule

// File: tb/vfd_cmd_rx_tb.sv
`timescale 1ns/1ps
module vfd_cmd_rx_tb;

    logic        cp = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        da = 1'b0;
    logic [1:0]  code_we, glyph_we, mark_we;
    logic [3:0]  code_addr, glyph_addr, mark_addr;
    logic [7:0]  code_data;
    logic [34:0] glyph_data;
    logic        mark_data;
    logic [9:0]  duty;
    logic [3:0]  digits;
    logic [1:0]  lamps;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0]  tx_q[$];
    logic [41:0] obs_q[$];
    logic [41:0] exp_q[$];
    logic [9:0]  e_duty = '0;
    logic [3:0]  e_digits = '0;
    logic [1:0]  e_lamps = 2'b01;

    always #4 cp = ~cp;

    vfd_cmd_rx u_dut (
        .cp(cp), .rst_n(rst_n), .cs_n(cs_n), .da(da),
        .code_we(code_we), .code_addr(code_addr), .code_data(code_data),
        .glyph_we(glyph_we), .glyph_addr(glyph_addr), .glyph_data(glyph_data),
        .mark_we(mark_we), .mark_addr(mark_addr), .mark_data(mark_data),
        .duty(duty), .digits(digits), .lamps(lamps)
    );

    // event word: {kind[1:0], bank, addr[3:0], data[34:0]}; kind 0 code, 1 glyph, 2 mark
    always @(negedge cp) begin
        if (rst_n) begin
            for (int b = 0; b < 2; b++) begin
                if (code_we[b])  obs_q.push_back({2'd0, b[0], code_addr, 27'd0, code_data});
                if (glyph_we[b]) obs_q.push_back({2'd1, b[0], glyph_addr, glyph_data});
                if (mark_we[b])  obs_q.push_back({2'd2, b[0], mark_addr, 34'd0, mark_data});
            end
        end
    end

    function automatic logic [34:0] pack_glyph(input logic [39:0] cols);
        logic [34:0] p;
        p = '0;
        for (int k = 0; k < 5; k++)
            for (int r = 0; r < 7; r++)
                p[k + 5*r] = cols[8*k + r];
        return p;
    endfunction

    function automatic logic [3:0] bad_nibble(input int s);
        case (s % 7)
            0: return 4'hF;
            1: return 4'h0;
            2: return 4'h8;
            3: return 4'h4;
            4: return 4'hC;
            5: return 4'hD;
            default: return 4'hE;
        endcase
    endfunction

    task automatic expect_ev(input logic [1:0] k, input logic bk, input logic [3:0] a,
                             input logic [34:0] d);
        exp_q.push_back({k, bk, a, d});
    endtask

    task automatic run_frame();
        for (int i = 0; i < tx_q.size(); i++) begin
            for (int j = 0; j < 8; j++) begin
                @(negedge cp);
                cs_n = 1'b0;
                da   = tx_q[i][j];
            end
        end
        @(negedge cp);
        cs_n = 1'b1;
        da   = 1'b0;
        repeat (2) @(negedge cp);
        tx_q.delete();
    endtask

    task automatic send_bits(input int n, input logic [7:0] v);
        for (int j = 0; j < n; j++) begin
            @(negedge cp);
            cs_n = 1'b0;
            da   = v[j];
        end
        @(negedge cp);
        cs_n = 1'b1;
        da   = 1'b0;
        repeat (2) @(negedge cp);
    endtask

    task automatic check_events(input string tag);
        tests++;
        if (obs_q.size() != exp_q.size()) begin
            fails++;
            $display("FAIL %s: write count %0d expected %0d", tag, obs_q.size(), exp_q.size());
        end else begin
            for (int i = 0; i < obs_q.size(); i++) begin
                tests++;
                if (obs_q[i] !== exp_q[i]) begin
                    fails++;
                    $display("FAIL %s: write %0d got %h expected %h", tag, i, obs_q[i], exp_q[i]);
                end
            end
        end
        obs_q.delete();
        exp_q.delete();
    endtask

    task automatic check_regs(input string tag);
        tests++;
        if (duty !== e_duty || digits !== e_digits || lamps !== e_lamps) begin
            fails++;
            $display("FAIL %s: duty/digits/lamps got %h/%h/%h expected %h/%h/%h",
                     tag, duty, digits, lamps, e_duty, e_digits, e_lamps);
        end
    endtask

    task automatic rand_mem_frame(input int kind);
        logic       bk;
        logic [3:0] a;
        int         n;
        bk = 1'($urandom);
        a  = 4'($urandom);
        n  = 1 + int'($urandom % 20);
        if (kind == 0) begin
            tx_q.push_back({bk, 3'b001, a});
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                d = 8'($urandom);
                tx_q.push_back(d);
                expect_ev(2'd0, bk, a, {27'd0, d});
                a = a + 1'b1;
            end
        end else if (kind == 1) begin
            tx_q.push_back({bk, 3'b010, a});
            for (int e = 0; e < 1 + (n % 4); e++) begin
                logic [39:0] cols;
                cols = {8'($urandom), 32'($urandom)};
                for (int k = 0; k < 5; k++) tx_q.push_back(cols[8*k +: 8]);
                expect_ev(2'd1, bk, a, pack_glyph(cols));
                a = a + 1'b1;
            end
        end else begin
            tx_q.push_back({bk, 3'b011, a});
            for (int i = 0; i < n; i++) begin
                logic [7:0] d;
                d = 8'($urandom);
                tx_q.push_back(d);
                expect_ev(2'd2, bk, a, {34'd0, d[0]});
                a = a + 1'b1;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd51966));
        repeat (3) @(negedge cp);
        rst_n = 1'b1;
        @(negedge cp);

        // R9 reset state
        tests++;
        if (code_we !== 2'b00 || glyph_we !== 2'b00 || mark_we !== 2'b00) begin
            fails++;
            $display("FAIL R9: strobes %b %b %b expected 00 00 00", code_we, glyph_we, mark_we);
        end
        check_regs("R9");

        // R1 R2 bit order: 01 and 80 differ only in which end is first
        tx_q = '{8'h13, 8'h01, 8'h80};
        expect_ev(2'd0, 1'b0, 4'd3, 35'h01);
        expect_ev(2'd0, 1'b0, 4'd4, 35'h80);
        run_frame();
        check_events("R1_R2 bit order");

        // R3 R5 wrap on marker bank B, only bit 0 stored
        tx_q = '{8'hBE, 8'hFE, 8'h01, 8'hFF, 8'h02};
        expect_ev(2'd2, 1'b1, 4'd14, 35'd0);
        expect_ev(2'd2, 1'b1, 4'd15, 35'd1);
        expect_ev(2'd2, 1'b1, 4'd0,  35'd1);
        expect_ev(2'd2, 1'b1, 4'd1,  35'd0);
        run_frame();
        check_events("R3_R5 wrap");

        // R4 glyph transpose, bit 7 set on some columns
        tx_q = '{8'h27, 8'hC1, 8'h63, 8'hD5, 8'h49, 8'hE3};
        expect_ev(2'd1, 1'b0, 4'd7, pack_glyph({8'h63, 8'h49, 8'h55, 8'h63, 8'h41}));
        run_frame();
        check_events("R4 glyph");

        // R11 abort after three glyph columns, then a clean entry
        tx_q = '{8'hA2, 8'h7F, 8'h7F, 8'h7F};
        run_frame();
        check_events("R11 abort");
        tx_q = '{8'hA2, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10};
        expect_ev(2'd1, 1'b1, 4'd2, pack_glyph({8'h10, 8'h08, 8'h04, 8'h02, 8'h01}));
        run_frame();
        check_events("R11 restart");

        // R1 partial byte discarded; next byte is a command
        send_bits(5, 8'h1F);
        tx_q = '{8'h69};
        e_digits = 4'h9;
        run_frame();
        check_events("R1 partial");
        check_regs("R1 partial");

        // R6 duty with a trailing byte ignored
        tx_q = '{8'h5E, 8'hB4, 8'h6F};
        e_duty = {8'hB4, 2'b10};
        run_frame();
        check_events("R6 duty");
        check_regs("R6 duty");

        // R7 lamps then following bytes ignored
        tx_q = '{8'h72, 8'h13, 8'h55};
        e_lamps = 2'b10;
        run_frame();
        check_events("R7 lamps");
        check_regs("R7 lamps");

        // R8 test code followed by command-looking bytes
        tx_q = '{8'hF3, 8'h64, 8'h12, 8'h77};
        run_frame();
        check_events("R8 test code");
        check_regs("R8 test code");

        // random mix
        for (int it = 0; it < 60; it++) begin
            int kind;
            kind = int'($urandom % 7);
            if (kind < 3) begin
                rand_mem_frame(kind);
            end else if (kind == 3) begin
                logic [7:0] hi;
                logic [1:0] lo;
                hi = 8'($urandom);
                lo = 2'($urandom);
                tx_q = '{{4'b0101, 2'($urandom), lo}, hi};
                if (it % 2 == 0) tx_q.push_back(8'($urandom));
                e_duty = {hi, lo};
            end else if (kind == 4) begin
                logic [3:0] k;
                k = 4'($urandom);
                tx_q = '{{4'b0110, k}, 8'($urandom)};
                e_digits = k;
            end else if (kind == 5) begin
                logic [3:0] l;
                l = 4'($urandom);
                tx_q = '{{4'b0111, l}};
                e_lamps = l[1:0];
            end else begin
                tx_q = '{{bad_nibble(int'($urandom % 7)), 4'($urandom)},
                         {4'b0110, 4'($urandom)}, 8'($urandom), 8'h5A};
            end
            run_frame();
            check_events(kind == 0 ? "R2 rand" : kind == 1 ? "R4 rand" :
                         kind == 2 ? "R5 rand" : kind == 6 ? "R8 rand" : "R7 rand");
            check_regs(kind == 3 ? "R6 rand" : kind == 6 ? "R8 rand" : "R7 rand");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge cp);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule